// File: doc/BRIEF.md
# Transport Packet Ring Writer

This block takes a byte stream of fixed-length transport packets and writes it into a circular region of host memory. The region is divided into blocks, and each block holds a whole number of packets. Software programs a start address, a packed geometry word and a timeout, then sets a run bit. Each byte is written to the next address, and the write address returns to the start once the last byte of the last block has gone out. Software reads the head address to see how far the data has progressed. An interrupt flag is raised when a block is finished, and also when the stream stalls partway through a block.

The input side cannot be stalled. A byte that arrives while the internal FIFO is full is dropped, and the drop is counted. The memory write side uses a valid/ready handshake: once `mem_valid` is high, it stays high and the address and data stay stable until the cycle in which `mem_ready` is high. Five saturating counters record traffic statistics. All registers are 32 bits wide and are reached through a word-indexed write port and a combinational read port.

Register word indices: 0 status/set, 1 clear, 2 start address, 3 geometry, 4 timeout, 5 head low, 6 head high, 7 top address bits, 8 to 12 statistics.

Top module: `ts_ring_writer`

## Requirements
- R1: After reset the run, error and interrupt flags are 0 and `mem_valid` is 0. Geometry reads 0x080080BC (188-byte packets, 128 per block, 8 blocks), timeout reads 375000000, and every statistics counter reads 0.
- R2: Writing a word with bit 0 set at index 0 sets the run flag. Writing it at index 1 clears the run flag. Reading index 0 or 1 returns the run flag in bit 0, the error flag in bit 1 and the interrupt flag in bit 9.
- R3: The base address is formed from bits [31:30] of the register at index 7 and bits [29:0] of the start register at index 2. The start register keeps only its low 30 bits. Bytes are written in arrival order to consecutive addresses from the base.
- R4: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values on the next cycle.
- R5: The geometry word holds the packet length in bits [7:0], packets per block in bits [15:8] and block count in bits [31:24]. The ring size is the product of the three. After the last byte of the ring, the next write goes to the base.
- R6: The head low word (index 5) reads the base plus the number of completed writes modulo the ring size. The head high word (index 6) reads 0.
- R7: A completed write that finishes a block sets the interrupt flag (`irq`). Writing 0x200 at index 1 clears it, unless a new set event occurs in the same cycle.
- R8: When the timeout value N is nonzero, the counter reloads to N on every completed write. It counts down while a block is partly filled, and the interrupt flag is set once N cycles pass with no write. N equal to 0 disables the timeout.
- R9: A byte presented while running and while the FIFO is full is dropped. The drop sets the error flag and increments the FIFO-overrun counter. Writing 0x2 at index 1 clears the error flag.
- R10: The statistics counters are: index 8 counts input packets (one per packet-length input bytes), 9 packets fully written, 10 input packets with at least one dropped byte, 11 timeouts that occur in the middle of a packet, and 12 dropped bytes.
- R11: After the run flag is cleared, a write already presented completes but no new write starts. Setting the run flag again discards the queued data and restarts writing at the base.
- R12: While the run flag is 0, input bytes are ignored. They are not queued, not written and not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Register word index for writes |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 4 | Register word index for reads |
| reg_rd_data | output | 32 | Register read data (combinational) |
| s_valid | input | 1 | Input byte present (no back-pressure) |
| s_data | input | 8 | Input byte |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory write accepted |
| mem_addr | output | 32 | Memory byte address |
| mem_data | output | 8 | Memory write byte |
| irq | output | 1 | Interrupt pending flag |

## Verification
On every cycle the assertions check three behaviours of the memory side: write requests stay stable under back-pressure, every presented address falls inside the programmed ring, and no write starts while the block is stopped. They also check that a drop raises the error flag and that acknowledge and stop writes take effect on the next cycle. The exact address sequence, including the wrap to the base, can only be shown by the bench's scenarios. The same holds for the counter values after an overflow burst, the timing of the stall interrupt, and the restart after a stop, because each of these depends on a whole stimulus history.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] RA_CTRL_SET = 4'd0;
  localparam logic [REG_AW-1:0] RA_CTRL_CLR = 4'd1;
  localparam logic [REG_AW-1:0] RA_START    = 4'd2;
  localparam logic [REG_AW-1:0] RA_GEOM     = 4'd3;
  localparam logic [REG_AW-1:0] RA_TMO      = 4'd4;
  localparam logic [REG_AW-1:0] RA_HEAD_LO  = 4'd5;
  localparam logic [REG_AW-1:0] RA_HEAD_HI  = 4'd6;
  localparam logic [REG_AW-1:0] RA_TOPBITS  = 4'd7;
  localparam logic [REG_AW-1:0] RA_STAT0    = 4'd8;

  localparam int NUM_STATS = 5;
  localparam logic [REG_AW-1:0] RA_STAT_LAST = RA_STAT0 + REG_AW'(NUM_STATS - 1);

  // status/control bit positions
  localparam int BIT_RUN = 0;
  localparam int BIT_ERR = 1;
  localparam int BIT_IRQ = 9;

  // statistics slots
  localparam int ST_RX   = 0;
  localparam int ST_ACC  = 1;
  localparam int ST_POVR = 2;
  localparam int ST_PUND = 3;
  localparam int ST_FOVR = 4;

  typedef struct packed {
    logic [7:0] blocks;
    logic [7:0] spare;
    logic [7:0] per_blk;
    logic [7:0] pkt_len;
  } geom_t;
endpackage

// File: rtl/tsw_regs.sv
module tsw_regs
  import tsw_pkg::*;
#(
  parameter logic [31:0] GEOM_RST = 32'h0800_80BC,
  parameter logic [31:0] TMO_RST  = 32'd375000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              irq_set,
  input  logic              err_set,
  output logic              run,
  output logic              restart,
  output logic              irq_pend,
  output logic              err_flag,
  output logic [29:0]       start_lo,
  output logic [1:0]        top_bits,
  output geom_t             geom,
  output logic [31:0]       tmo_val
);
  logic set_wr, clr_wr;

  assign set_wr  = wr_en && (wr_addr == RA_CTRL_SET);
  assign clr_wr  = wr_en && (wr_addr == RA_CTRL_CLR);
  assign restart = set_wr && wr_data[BIT_RUN] && !run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      irq_pend <= 1'b0;
      err_flag <= 1'b0;
      start_lo <= '0;
      top_bits <= '0;
      geom     <= geom_t'(GEOM_RST);
      tmo_val  <= TMO_RST;
    end else begin
      if (set_wr && wr_data[BIT_RUN])      run <= 1'b1;
      else if (clr_wr && wr_data[BIT_RUN]) run <= 1'b0;

      if (irq_set)                         irq_pend <= 1'b1;
      else if (clr_wr && wr_data[BIT_IRQ]) irq_pend <= 1'b0;

      if (err_set)                         err_flag <= 1'b1;
      else if (clr_wr && wr_data[BIT_ERR]) err_flag <= 1'b0;

      if (wr_en) begin
        case (wr_addr)
          RA_START:   start_lo <= wr_data[29:0];
          RA_TOPBITS: top_bits <= wr_data[31:30];
          RA_GEOM:    geom     <= geom_t'(wr_data);
          RA_TMO:     tmo_val  <= wr_data;
          default:    ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tsw_fifo.sv
module tsw_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
      case ({push && !full, pop && !empty})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tsw_writer.sv
module tsw_writer #(
  parameter int FW = 8,
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic [AW-1:0]   base,
  input  logic [FW-1:0]   pkt_len,
  input  logic [FW-1:0]   per_blk,
  input  logic [FW-1:0]   blk_cnt,
  input  logic [31:0]     tmo_val,
  input  logic            fifo_empty,
  input  logic [7:0]      fifo_dout,
  output logic            fifo_pop,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic [AW-1:0]   mem_addr,
  output logic [7:0]      mem_data,
  output logic [AW-1:0]   head,
  output logic [3*FW-1:0] ring_bytes,
  output logic            blk_done,
  output logic            pkt_done,
  output logic            tmo_fire,
  output logic            tmo_mid_pkt
);
  localparam int BW = 2 * FW;
  localparam int OW = 3 * FW;

  logic [BW-1:0] blk_bytes;
  logic [OW-1:0] iss_off, done_off;
  logic [BW-1:0] blk_pos;
  logic [FW-1:0] pkt_pos;
  logic [31:0]   tmo_cnt;
  logic          load, beat, tmo_dec;

  assign blk_bytes  = {{FW{1'b0}}, pkt_len} * {{FW{1'b0}}, per_blk};
  assign ring_bytes = {{FW{1'b0}}, blk_bytes} * {{BW{1'b0}}, blk_cnt};

  assign beat     = mem_valid && mem_ready;
  assign load     = run && !fifo_empty && (!mem_valid || mem_ready);
  assign fifo_pop = load;

  assign blk_done    = beat && (blk_pos == blk_bytes - 1'b1);
  assign pkt_done    = beat && (pkt_pos == pkt_len - 1'b1);
  assign tmo_dec     = run && (tmo_cnt != '0) && (blk_pos != '0);
  assign tmo_fire    = tmo_dec && (tmo_cnt == 32'd1);
  assign tmo_mid_pkt = tmo_fire && (pkt_pos != '0);

  assign head = base + {{(AW-OW){1'b0}}, done_off};

  function automatic logic [OW-1:0] ring_next(input logic [OW-1:0] v, input logic [OW-1:0] sz);
    return (v == sz - 1'b1) ? '0 : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
      iss_off   <= '0;
      done_off  <= '0;
      blk_pos   <= '0;
      pkt_pos   <= '0;
      tmo_cnt   <= '0;
    end else begin
      if (load) begin
        mem_valid <= 1'b1;
        mem_addr  <= base + {{(AW-OW){1'b0}}, iss_off};
        mem_data  <= fifo_dout;
      end else if (beat) begin
        mem_valid <= 1'b0;
      end

      if (restart) begin
        iss_off  <= '0;
        done_off <= '0;
        blk_pos  <= '0;
        pkt_pos  <= '0;
        tmo_cnt  <= '0;
      end else begin
        if (load) iss_off <= ring_next(iss_off, ring_bytes);
        if (beat) begin
          done_off <= ring_next(done_off, ring_bytes);
          blk_pos  <= blk_done ? '0 : blk_pos + 1'b1;
          pkt_pos  <= pkt_done ? '0 : pkt_pos + 1'b1;
          tmo_cnt  <= tmo_val;
        end else if (tmo_dec) begin
          tmo_cnt <= tmo_cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tsw_stats.sv
module tsw_stats #(
  parameter int N = 5,
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] inc,
  output logic [W-1:0] cnt [N]
);
  for (genvar i = 0; i < N; i++) begin : g_cnt
    logic [W-1:0] c;
    always_ff @(posedge clk) begin
      if (!rst_n)                c <= '0;
      else if (inc[i] && c != '1) c <= c + 1'b1;
    end
    assign cnt[i] = c;
  end
endmodule

// File: rtl/ts_ring_writer.sv
module ts_ring_writer
  import tsw_pkg::*;
#(
  parameter int          FIFO_DEPTH = 16,
  parameter int          CNT_W      = 16,
  parameter logic [31:0] GEOM_RST   = 32'h0800_80BC,
  parameter logic [31:0] TMO_RST    = 32'd375000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_wr_addr,
  input  logic [31:0]       reg_wr_data,
  input  logic [REG_AW-1:0] reg_rd_addr,
  output logic [31:0]       reg_rd_data,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [31:0]       mem_addr,
  output logic [7:0]        mem_data,
  output logic              irq
);
  localparam int FW = 8;
  localparam int OW = 3 * FW;

  logic        run, restart, err_flag, irq_pend;
  logic [29:0] start_lo;
  logic [1:0]  top_bits;
  geom_t       geom;
  logic [31:0] tmo_val, base_addr, head;
  logic [OW-1:0] ring_bytes;
  logic        fifo_empty, fifo_full, fifo_pop;
  logic [7:0]  fifo_dout;
  logic        blk_done, pkt_done, tmo_fire, tmo_mid_pkt;
  logic        in_take, in_push, in_drop, in_last, drop_seen;
  logic [FW-1:0] in_pos;
  logic [NUM_STATS-1:0] stat_inc;
  logic [CNT_W-1:0] stat_cnt [NUM_STATS];
  logic [2:0]  stat_idx;

  assign base_addr = {top_bits, start_lo};
  assign irq       = irq_pend;

  tsw_regs #(.GEOM_RST(GEOM_RST), .TMO_RST(TMO_RST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .irq_set(blk_done || tmo_fire), .err_set(in_drop),
    .run(run), .restart(restart), .irq_pend(irq_pend), .err_flag(err_flag),
    .start_lo(start_lo), .top_bits(top_bits), .geom(geom), .tmo_val(tmo_val)
  );

  // input side: never stalls, drops when full
  assign in_take = run && s_valid;
  assign in_push = in_take && !fifo_full;
  assign in_drop = in_take && fifo_full;
  assign in_last = in_take && (in_pos == geom.pkt_len - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      in_pos    <= '0;
      drop_seen <= 1'b0;
    end else if (in_take) begin
      in_pos    <= in_last ? '0 : in_pos + 1'b1;
      drop_seen <= in_last ? 1'b0 : (drop_seen || in_drop);
    end
  end

  tsw_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(restart),
    .push(in_push), .din(s_data), .pop(fifo_pop), .dout(fifo_dout),
    .empty(fifo_empty), .full(fifo_full)
  );

  tsw_writer #(.FW(FW), .AW(32)) u_wr (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
    .base(base_addr), .pkt_len(geom.pkt_len), .per_blk(geom.per_blk), .blk_cnt(geom.blocks),
    .tmo_val(tmo_val), .fifo_empty(fifo_empty), .fifo_dout(fifo_dout), .fifo_pop(fifo_pop),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .head(head), .ring_bytes(ring_bytes), .blk_done(blk_done), .pkt_done(pkt_done),
    .tmo_fire(tmo_fire), .tmo_mid_pkt(tmo_mid_pkt)
  );

  always_comb begin
    stat_inc          = '0;
    stat_inc[ST_RX]   = in_last;
    stat_inc[ST_ACC]  = pkt_done;
    stat_inc[ST_POVR] = in_last && (in_drop || drop_seen);
    stat_inc[ST_PUND] = tmo_mid_pkt;
    stat_inc[ST_FOVR] = in_drop;
  end

  tsw_stats #(.N(NUM_STATS), .W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .inc(stat_inc), .cnt(stat_cnt)
  );

  assign stat_idx = 3'(reg_rd_addr - RA_STAT0);

  always_comb begin
    reg_rd_data = '0;
    case (reg_rd_addr)
      RA_CTRL_SET, RA_CTRL_CLR: begin
        reg_rd_data[BIT_RUN] = run;
        reg_rd_data[BIT_ERR] = err_flag;
        reg_rd_data[BIT_IRQ] = irq_pend;
      end
      RA_START:   reg_rd_data = {2'b00, start_lo};
      RA_GEOM:    reg_rd_data = geom;
      RA_TMO:     reg_rd_data = tmo_val;
      RA_HEAD_LO: reg_rd_data = head;
      RA_HEAD_HI: reg_rd_data = '0;
      RA_TOPBITS: reg_rd_data = {top_bits, 30'b0};
      default: begin
        if (reg_rd_addr >= RA_STAT0 && reg_rd_addr <= RA_STAT_LAST)
          reg_rd_data = 32'(stat_cnt[stat_idx]);
      end
    endcase
  end
endmodule

// File: rtl/ts_ring_writer_chk.sv
module ts_ring_writer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic [7:0]  mem_data,
  input logic [31:0] base_addr,
  input logic [23:0] ring_bytes,
  input logic        run,
  input logic        err_flag,
  input logic        irq,
  input logic        fifo_full,
  input logic        s_valid,
  input logic        blk_done,
  input logic        tmo_fire,
  input logic        irq_ack_wr,
  input logic        run_clr_wr
);
  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  // R5
  in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ((mem_addr - base_addr) < {8'b0, ring_bytes}));

  // R7
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_wr && !blk_done && !tmo_fire |=> !irq);

  // R9
  drop_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && s_valid && fifo_full |=> err_flag);

  // R11
  no_issue_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !mem_valid |=> !mem_valid);

  // R2
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_clr_wr |=> !run);
endmodule

bind ts_ring_writer ts_ring_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
  .base_addr(base_addr), .ring_bytes(ring_bytes),
  .run(run), .err_flag(err_flag), .irq(irq), .fifo_full(fifo_full), .s_valid(s_valid),
  .blk_done(blk_done), .tmo_fire(tmo_fire),
  .irq_ack_wr(reg_wr_en && (reg_wr_addr == tsw_pkg::RA_CTRL_CLR) && reg_wr_data[tsw_pkg::BIT_IRQ]),
  .run_clr_wr(reg_wr_en && (reg_wr_addr == tsw_pkg::RA_CTRL_CLR) && reg_wr_data[tsw_pkg::BIT_RUN])
);

// File: tb/ts_ring_writer_tb.sv
module ts_ring_writer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [3:0]  reg_rd_addr = '0;
  logic [31:0] reg_rd_data;
  logic        s_valid = 1'b0;
  logic [7:0]  s_data = '0;
  logic        mem_valid, mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [7:0]  mem_data;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] log_a [64];
  logic [7:0]  log_d [64];
  int log_n = 0;

  localparam logic [31:0] BASE = 32'h8000_1000;
  localparam int RING = 24;

  always #5 clk = ~clk;

  ts_ring_writer u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .s_valid(s_valid), .s_data(s_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .irq(irq)
  );

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (log_n < 64) begin
        log_a[log_n] <= mem_addr;
        log_d[log_n] <= mem_data;
      end
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    reg_rd_addr = a;
    #1;
    d = reg_rd_data;
  endtask

  task automatic send(input int n, input logic [7:0] first);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = first + 8'(i);
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic restart();
    reg_wr(4'd1, 32'h1);
    reg_wr(4'd0, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_rd(4'd0, v);  chk("R1 status", v, 32'h0);
    reg_rd(4'd3, v);  chk("R1 geometry", v, 32'h0800_80BC);
    reg_rd(4'd4, v);  chk("R1 timeout", v, 32'd375000000);
    reg_rd(4'd8, v);  chk("R1 rx count", v, 0);
    reg_rd(4'd12, v); chk("R1 drop count", v, 0);
    chk("R1 mem_valid", {31'b0, mem_valid}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    reg_wr(4'd0, 32'h1);
    reg_rd(4'd0, v); chk("R2 run set", v, 32'h1);
    reg_wr(4'd1, 32'h1);
    reg_rd(4'd0, v); chk("R2 run clear", v, 32'h0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    int mark;
    reg_wr(4'd2, 32'hC000_1000);
    reg_wr(4'd7, 32'h8000_0000);
    reg_wr(4'd3, 32'h0300_0204);   // 4-byte packets, 2 per block, 3 blocks
    reg_wr(4'd4, 32'd0);
    reg_rd(4'd2, v); chk("R3 start keeps low 30 bits", v, 32'h0000_1000);
    mem_ready = 1'b1;
    restart();
    mark = log_n;
    send(8, 8'h10);
    idle(8);
    chk("R3 write count", 32'(log_n - mark), 8);
    for (int i = 0; i < 8; i++) begin
      chk("R3 address", log_a[mark+i], BASE + 32'(i));
      chk("R3 data", {24'b0, log_d[mark+i]}, 32'h10 + 32'(i));
    end
    chk("R7 irq after block", {31'b0, irq}, 1);
    reg_rd(4'd0, v); chk("R7 status irq bit", v & 32'h200, 32'h200);
    reg_rd(4'd5, v); chk("R6 head low", v, BASE + 8);
    reg_rd(4'd6, v); chk("R6 head high", v, 0);
    reg_wr(4'd1, 32'h200);
    chk("R7 irq acknowledged", {31'b0, irq}, 0);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    int mark;
    mark = log_n;
    send(16, 8'h40);
    idle(8);
    chk("R7 irq after two blocks", {31'b0, irq}, 1);
    reg_wr(4'd1, 32'h200);
    send(2, 8'h60);
    idle(8);
    chk("R8 disabled timeout keeps irq low", {31'b0, irq}, 0);
    chk("R5 write count", 32'(log_n - mark), 18);
    for (int i = 0; i < 18; i++)
      chk("R5 wrapped address", log_a[mark+i], BASE + 32'((8 + i) % RING));
    reg_rd(4'd5, v); chk("R6 head after wrap", v, BASE + 2);
  endtask

  task automatic t_backpressure();
    logic [31:0] a1;
    int mark;
    restart();
    mem_ready = 1'b0;
    mark = log_n;
    send(3, 8'h70);
    idle(2);
    a1 = mem_addr;
    idle(3);
    chk("R4 valid held", {31'b0, mem_valid}, 1);
    chk("R4 address held", mem_addr, a1);
    chk("R11 restart at base", mem_addr, BASE);
    chk("R4 data held", {24'b0, mem_data}, 32'h70);
    chk("R4 no write while stalled", 32'(log_n - mark), 0);
    mem_ready = 1'b1;
    idle(6);
    chk("R4 drained count", 32'(log_n - mark), 3);
    for (int i = 0; i < 3; i++)
      chk("R4 drained order", {24'b0, log_d[mark+i]}, 32'h70 + 32'(i));
    reg_wr(4'd1, 32'h200);
  endtask

  task automatic t_overflow();
    logic [31:0] fo0, rx0, po0, v;
    int mark;
    restart();
    reg_rd(4'd12, fo0); reg_rd(4'd8, rx0); reg_rd(4'd10, po0);
    mem_ready = 1'b0;
    mark = log_n;
    send(20, 8'h00);
    idle(2);
    reg_rd(4'd12, v); chk("R9 drop count", v - fo0, 3);
    reg_rd(4'd0, v);  chk("R9 error flag", v & 32'h2, 32'h2);
    reg_rd(4'd8, v);  chk("R10 rx packets", v - rx0, 5);
    reg_rd(4'd10, v); chk("R10 packet overruns", v - po0, 1);
    mem_ready = 1'b1;
    idle(25);
    chk("R9 kept bytes", 32'(log_n - mark), 17);
    chk("R9 last kept byte", {24'b0, log_d[mark+16]}, 32'd16);
    reg_wr(4'd1, 32'h202);
    reg_rd(4'd0, v); chk("R9 error cleared", v & 32'h202, 0);
  endtask

  task automatic t_timeout();
    logic [31:0] u0, v;
    restart();
    reg_wr(4'd4, 32'd20);
    reg_rd(4'd11, u0);
    mem_ready = 1'b1;
    send(5, 8'h90);
    idle(10);
    chk("R8 no irq before expiry", {31'b0, irq}, 0);
    idle(25);
    chk("R8 irq on stall", {31'b0, irq}, 1);
    reg_rd(4'd11, v); chk("R10 mid-packet timeout", v - u0, 1);
    reg_wr(4'd4, 32'd0);
    reg_wr(4'd1, 32'h200);
  endtask

  task automatic t_stop();
    logic [31:0] r0, v;
    int mark;
    restart();
    mem_ready = 1'b0;
    mark = log_n;
    send(2, 8'hA0);
    idle(3);
    reg_wr(4'd1, 32'h1);
    mem_ready = 1'b1;
    idle(5);
    chk("R11 in-flight write completes", 32'(log_n - mark), 1);
    chk("R11 in-flight data", {24'b0, log_d[mark]}, 32'hA0);
    chk("R11 no new write", {31'b0, mem_valid}, 0);
    reg_rd(4'd8, r0);
    send(4, 8'hB0);
    idle(5);
    chk("R12 no write while stopped", 32'(log_n - mark), 1);
    reg_rd(4'd8, v); chk("R12 not counted", v, r0);
    reg_wr(4'd0, 32'h1);
    send(1, 8'hC0);
    idle(5);
    chk("R11 restart count", 32'(log_n - mark), 2);
    chk("R11 restart address", log_a[mark+1], BASE);
    chk("R11 restart data", {24'b0, log_d[mark+1]}, 32'hC0);
  endtask

  task automatic t_stats();
    logic [31:0] rx0, ac0, v;
    restart();
    reg_rd(4'd8, rx0); reg_rd(4'd9, ac0);
    mem_ready = 1'b1;
    send(12, 8'h20);
    idle(10);
    reg_rd(4'd8, v); chk("R10 rx packets", v - rx0, 3);
    reg_rd(4'd9, v); chk("R10 accepted packets", v - ac0, 3);
    reg_wr(4'd1, 32'h200);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wrap();
    t_backpressure();
    t_overflow();
    t_timeout();
    t_stop();
    t_stats();
    summary();
    $finish;
  end
endmodule